// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block sits beside the command decoder of a serial memory and decides, access by access, whether a write may change its target. It holds a volatile write-enable latch and the protection bits that would be non-volatile in a real part. Here those bits are plain registers that reset to zero. The protection bits are a two-bit array-protect code, a register-window lock and a protect-enable bit. The block also samples a hardware write-protect pin.

The decoder sends single-cycle strobes for write-enable, write-disable and write-completed, a status-register write strobe with its data byte, and the current target address. The block returns a combinational grant for the addressed memory write and one for a status-register write, along with the status byte the decoder shifts out on a read.

Top module: `spi_wp_guard`

## Requirements
- R1: After reset the write-enable latch and all protection bits are 0, so the status byte reads 00h. Only a write-enable strobe sets the latch.
- R2: While the write-enable latch is 0, both `mem_grant` and `sr_grant` are 0 for every address and every pin level.
- R3: The array-protect code {sr bit3, sr bit2} guards addresses 000h–0FFh:
  - 00 protects nothing.
  - 01 protects 0C0h–0FFh.
  - 10 protects 080h–0FFh.
  - 11 protects all of 000h–0FFh.
- R4: When the register-window lock (sr bit4) is 1, addresses 120h–135h are denied. Addresses 100h–11Fh, including 10Ah–10Fh, are not affected by this bit.
- R5: Addresses above 135h are never granted.
- R6: When protect-enable (sr bit7) is 1 and `wp_pin` is 0, `sr_grant` is 0. A status write then leaves all protection bits unchanged, protect-enable included.
- R7: When protect-enable is 0, `wp_pin` has no effect. When `wp_pin` is 1, status writes are allowed even if protect-enable is 1.
- R8: The status byte places the write-enable latch at bit1, the array-protect code at bits 3:2, the register-window lock at bit4 and protect-enable at bit7. All other bits read 0.
- R9: A write-disable or write-completed strobe clears the latch at the next edge. If either arrives in the same cycle as a write-enable strobe, the clear wins.
- R10: A status write with `sr_grant` high loads bits 7, 4, 3 and 2 of `sr_wdata` into the protection bits at the next edge. It uses the latch value from before any clear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| wr_done | input | 1 | Write command terminated strobe |
| sr_wr | input | 1 | Status-register write strobe |
| sr_wdata | input | 8 | Status-register write data |
| wr_addr | input | 9 | Target address of a memory write |
| wp_pin | input | 1 | Hardware write-protect pin, low protects |
| mem_grant | output | 1 | Memory write to `wr_addr` allowed |
| sr_grant | output | 1 | Status-register write allowed |
| sr_rdata | output | 8 | Status-register read value |

## Verification
The hardest state to reach from the ports is the self-lock: protect-enable set while the pin is low. Protect-enable can only be written while the pin is inactive or protect-enable is still 0.

The stimulus first raises the latch and writes protect-enable with the pin low, which is legal because protect-enable is still 0. It then attempts writes that would clear every protection bit and checks that nothing moves. Only after that does it raise the pin and release the lock. The same sequence also covers a write-completed strobe arriving together with a status write, which must still apply the data.

// File: rtl/spi_wp_guard.sv
module spi_wp_guard #(
  parameter int AW         = 9,
  parameter int ARRAY_LAST = 'h0FF,
  parameter int REG_FIRST  = 'h120,
  parameter int REG_LAST   = 'h135
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          wr_done,
  input  logic          sr_wr,
  input  logic [7:0]    sr_wdata,
  input  logic [AW-1:0] wr_addr,
  input  logic          wp_pin,
  output logic          mem_grant,
  output logic          sr_grant,
  output logic [7:0]    sr_rdata
);
  localparam int SPAN = ARRAY_LAST + 1;

  logic       wel, rlock, pe;
  logic [1:0] bp;
  logic [AW:0] bp_lo;
  logic in_array, in_reg, zone_ok;

  always_comb begin
    case (bp)
      2'b00:   bp_lo = (AW+1)'(SPAN);
      2'b01:   bp_lo = (AW+1)'(SPAN - SPAN/4);
      2'b10:   bp_lo = (AW+1)'(SPAN/2);
      default: bp_lo = '0;
    endcase
  end

  assign in_array = int'(wr_addr) <= ARRAY_LAST;
  assign in_reg   = int'(wr_addr) >= REG_FIRST && int'(wr_addr) <= REG_LAST;
  assign zone_ok  = in_array ? ({1'b0, wr_addr} < bp_lo)
                  : in_reg   ? !rlock
                  : int'(wr_addr) <= REG_LAST;

  assign mem_grant = wel & zone_ok;
  assign sr_grant  = wel & !(pe & !wp_pin);
  assign sr_rdata  = {pe, 2'b00, rlock, bp, wel, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel   <= 1'b0;
      bp    <= 2'b00;
      rlock <= 1'b0;
      pe    <= 1'b0;
    end else begin
      if (cmd_wrdi || wr_done) wel <= 1'b0;
      else if (cmd_wren)       wel <= 1'b1;
      if (sr_wr && sr_grant) begin
        pe    <= sr_wdata[7];
        rlock <= sr_wdata[4];
        bp    <= sr_wdata[3:2];
      end
    end
  end
endmodule

module spi_wp_guard_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wren,
  input logic          cmd_wrdi,
  input logic          wr_done,
  input logic          sr_wr,
  input logic [AW-1:0] wr_addr,
  input logic          wp_pin,
  input logic          mem_grant,
  input logic          sr_grant,
  input logic [7:0]    sr_rdata
);
  assert_wel_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_rdata[1]) |-> $past(cmd_wren));
  assert_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_rdata[1] |-> (!mem_grant && !sr_grant));
  assert_bp_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata[3:2] == 2'b11 && int'(wr_addr) <= 'h0FF) |-> !mem_grant);
  assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata[4] && int'(wr_addr) >= 'h120 && int'(wr_addr) <= 'h135) |-> !mem_grant);
  assert_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_addr) > 'h135 |-> !mem_grant);
  assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata[7] && !wp_pin && sr_wr) |=> $stable(sr_rdata[7:2]));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrdi || wr_done) |=> !sr_rdata[1]);
  assert_unused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata[6:5] == 2'b00 && sr_rdata[0] == 1'b0));
endmodule

bind spi_wp_guard spi_wp_guard_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
  .wr_done(wr_done), .sr_wr(sr_wr), .wr_addr(wr_addr), .wp_pin(wp_pin),
  .mem_grant(mem_grant), .sr_grant(sr_grant), .sr_rdata(sr_rdata)
);

// File: tb/tb_spi_wp_guard.sv
module tb_spi_wp_guard;
  logic clk = 0, rst_n = 0;
  logic cmd_wren = 0, cmd_wrdi = 0, wr_done = 0, sr_wr = 0, wp_pin = 0;
  logic [7:0] sr_wdata = 0;
  logic [8:0] wr_addr = 0;
  logic mem_grant, sr_grant;
  logic [7:0] sr_rdata;
  int checks = 0, fails = 0;
  int m_wel = 0, m_bp = 0, m_rl = 0, m_pe = 0;

  always #5 clk = ~clk;

  spi_wp_guard dut (.*);

  function automatic logic [7:0] srb(int pe, int rl, int bp);
    return {pe[0], 2'b00, rl[0], bp[1:0], 2'b00};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_zone(int a);
    int lo;
    lo = (m_bp == 0) ? 256 : (m_bp == 1) ? 192 : (m_bp == 2) ? 128 : 0;
    if (a <= 'hFF) return (a < lo) ? 1 : 0;
    if (a >= 'h120 && a <= 'h135) return m_rl ? 0 : 1;
    return (a <= 'h135) ? 1 : 0;
  endfunction

  task automatic cyc(bit wren, bit wrdi, bit done, bit srw, logic [7:0] d,
                     int a, bit pin);
    string tg;
    int sg;
    cmd_wren = wren; cmd_wrdi = wrdi; wr_done = done; sr_wr = srw;
    sr_wdata = d; wr_addr = a[8:0]; wp_pin = pin;
    #1;
    tg = !m_wel ? "R2" : (a <= 'hFF) ? "R3" :
         (a >= 'h120 && a <= 'h135) ? "R4" : (a > 'h135) ? "R5" : "R4 lower";
    chk(tg, mem_grant, m_wel & m_zone(a));
    sg = m_wel & !(m_pe & !pin);
    chk(!m_wel ? "R2" : m_pe ? "R6 R7" : "R7", sr_grant, sg);
    chk("R8", sr_rdata, {m_pe[0], 2'b00, m_rl[0], m_bp[1:0], m_wel[0], 1'b0});
    @(posedge clk);
    if (srw && sg) begin m_pe = d[7]; m_rl = d[4]; m_bp = d[3:2]; end
    if (wrdi || done) m_wel = 0; else if (wren) m_wel = 1;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk("R1", sr_rdata, 0);
    cyc(0,0,0,0,0,'h000,1);
    cyc(0,0,0,1,8'hFF,'h050,1);          // R2 denied status write
    cyc(0,0,0,0,0,'h050,1);
    cyc(1,0,0,0,0,'h050,0);              // R1 set
    cyc(0,0,1,1,srb(0,0,1),'h0BF,0);     // R10 with done same cycle
    cyc(0,0,0,0,0,'h0BF,0);
    cyc(1,0,0,0,0,'h0BF,0);
    cyc(0,0,0,0,0,'h0C0,0);
    cyc(0,0,0,0,0,'h0FF,0);
    cyc(0,0,0,1,srb(0,0,2),'h07F,0);
    cyc(0,0,0,0,0,'h07F,0);
    cyc(0,0,0,0,0,'h080,0);
    cyc(0,0,0,1,srb(0,1,3),'h000,0);
    cyc(0,0,0,0,0,'h000,0);
    cyc(0,0,0,0,0,'h0FF,0);
    cyc(0,0,0,0,0,'h10A,0);
    cyc(0,0,0,0,0,'h11F,0);
    cyc(0,0,0,0,0,'h120,0);
    cyc(0,0,0,0,0,'h135,0);
    cyc(0,0,0,0,0,'h136,0);
    cyc(0,0,0,0,0,'h1FF,0);
    cyc(0,0,0,1,srb(0,0,0),'h120,0);
    cyc(0,0,0,0,0,'h120,0);
    cyc(0,0,0,0,0,'h0FF,0);
    cyc(0,0,0,0,0,'h136,1);
    cyc(0,1,0,0,0,'h000,1);              // R9 write-disable
    cyc(0,0,0,0,0,'h000,1);
    cyc(1,1,0,0,0,'h000,1);              // R9 clear wins
    cyc(1,0,0,0,0,'h000,1);
    cyc(1,0,1,0,0,'h000,1);              // R9 done wins
    cyc(1,0,0,0,0,'h000,0);
    cyc(0,0,0,1,srb(1,1,2),'h000,0);     // R7 pin ignored with pe=0
    cyc(0,0,0,1,srb(0,0,0),'h000,0);     // R6 self-lock
    cyc(0,0,0,1,srb(0,0,0),'h000,0);
    cyc(0,0,0,0,0,'h07F,0);
    cyc(0,0,0,0,0,'h080,0);
    cyc(0,0,0,1,srb(1,0,1),'h0C0,1);     // R7 pin high releases
    cyc(0,0,0,0,0,'h0C0,1);
    cyc(0,0,0,1,srb(0,0,0),'h000,1);
    cyc(0,0,0,0,0,'h000,0);
    cyc(1,0,0,0,0,'h000,0);
    cyc(0,0,1,0,0,'h000,0);
    cyc(0,0,0,0,0,'h000,0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule